// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver with Filtered Receive Buffer

This block receives frames on an asynchronous serial line. It oversamples the line at sixteen ticks per bit and reads each bit at mid-bit. It rebuilds the data word and then decides whether the frame is sound. The frame shape is chosen at run time: five to eight data bits, no parity or even or odd parity, and one or two stop bits. The shape is captured when a start bit is accepted, so a change made during a frame does not affect that frame.

Only frames whose parity and stop bits are correct enter a four-entry first-in first-out buffer. A frame with a bad parity bit, a low stop bit, or no free entry is discarded. Each of these three causes sets its own sticky flag, which stays set until a clear strobe arrives. A consumer sees the oldest stored word on the output at all times while the buffer is not empty, and removes it with a one-cycle read strobe.

The tick rate comes from a run-time divisor, so one build serves many line rates.

Top module: `rx_frame_buffer`

## Requirements
- R1: `dataBitsSel` selects the data bit count: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits arrive least significant bit first, and the stored word is the received bits zero-extended to 8 bits.
- R2: `parityMode` 1 selects even parity, 2 selects odd parity, and 0 or 3 selects no parity. When enabled, the parity bit follows the last data bit. A frame whose ones count (data plus parity) does not match the mode is not stored and sets `parityErr`.
- R3: `twoStop` 0 selects one stop bit and 1 selects two. A frame with any stop bit read low is not stored and sets `frameErr`.
- R4: The buffer is first-in first-out with four entries. `rdData` shows the oldest entry whenever `empty` is 0. A one-cycle `rdEn` removes that entry. `rdEn` while empty has no effect.
- R5: `empty` is 1 exactly when no entry is held. `full` is 1 exactly when four entries are held. The two are never 1 together.
- R6: A sound frame that completes while the buffer is full, with no read in that cycle, is discarded and sets `overrunErr`. The stored entries are unchanged.
- R7: When a sound frame completes in the same cycle as a read of a full buffer, the read removes the oldest entry and the new frame is stored. `overrunErr` stays clear and `full` stays 1.
- R8: `parityErr`, `frameErr` and `overrunErr` hold until `errClr` is high at a clock edge. An error that occurs in the same cycle as `errClr` leaves its flag set.
- R9: A tick occurs every `tickDiv`+1 clocks. Each bit lasts 16 ticks. A start bit that is no longer low 8 ticks after it was first seen is ignored and produces no store and no flag.
- R10: With `tickDiv` 0, the store or flag caused by a frame takes effect at the rising edge numbered 11+16K. Edges are counted from the first rising edge after the start bit is driven onto `rxd`, and K is the number of data, parity and stop bits.
- R11: After reset, `empty` is 1, `full` is 0, `rdData` is 0, and all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial line, idle high |
| dataBitsSel | input | 2 | Data bit count select (R1) |
| parityMode | input | 2 | Parity select (R2) |
| twoStop | input | 1 | Two stop bits when 1 |
| tickDiv | input | DIV_W | Clocks per oversample tick, minus one |
| rdEn | input | 1 | Remove the oldest buffered word |
| errClr | input | 1 | Clear the sticky error flags |
| rdData | output | 8 | Oldest buffered word |
| empty | output | 1 | Buffer holds no entry |
| full | output | 1 | Buffer holds four entries |
| parityErr | output | 1 | Sticky: frame rejected on parity |
| frameErr | output | 1 | Sticky: frame rejected on a low stop bit |
| overrunErr | output | 1 | Sticky: sound frame dropped, buffer full |

## Verification
A frame's completion, which writes the buffer or raises a flag, can fall in the same clock as a consumer's read, and also in the same clock as a flag clear. Because the completion edge is fixed by R10, the bench schedules `rdEn` and `errClr` pulses onto that exact edge. It does this once with a full buffer and once with a rejected frame. The outcomes are judged by a behavioural queue model that applies the read before the write and the clear before the set. The model is compared with the ports on every clock, and the drained contents are checked word by word.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
  localparam int WORD_W = 8;

  // Strobes and the captured frame shape, sent from control to datapath.
  typedef struct packed {
    logic       start;    // start bit accepted, clear accumulators
    logic       dataStb;  // sample a data bit
    logic       parStb;   // sample the parity bit
    logic       stopStb;  // sample a stop bit
    logic       done;     // last stop bit sampled this cycle
    logic       bitVal;   // synchronized line value
    logic [3:0] nData;    // data bits in this frame
    logic       parOn;
    logic       parOdd;
  } rxStrobes_t;
endpackage

// File: rtl/rxfb_ctrl.sv
module rxfb_ctrl
  import rxfb_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxd,
  input  logic [1:0]       dataBitsSel,
  input  logic [1:0]       parityMode,
  input  logic             twoStop,
  input  logic [DIV_W-1:0] tickDiv,
  output rxStrobes_t       stb
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID_PT = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] END_PT = CNT_W'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rxState_e;

  logic [1:0]       syncQ;
  logic             rxdS;
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  rxState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic [3:0]       bitCnt;
  logic             stopCnt;
  logic [3:0]       fmtBits;
  logic             fmtParOn;
  logic             fmtParOdd;
  logic             fmtTwo;
  logic             atEnd;

  // Two-flop synchronizer, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxd};
  end
  assign rxdS = syncQ[1];

  // Oversample tick divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end
  assign tick  = (divCnt >= tickDiv);
  assign atEnd = tick && (tickCnt == END_PT);

  always_comb begin
    stb         = '0;
    stb.start   = (state == S_IDLE) && tick && !rxdS;
    stb.dataStb = (state == S_DATA) && atEnd;
    stb.parStb  = (state == S_PAR) && atEnd;
    stb.stopStb = (state == S_STOP) && atEnd;
    stb.done    = (state == S_STOP) && atEnd && (stopCnt == fmtTwo);
    stb.bitVal  = rxdS;
    stb.nData   = fmtBits;
    stb.parOn   = fmtParOn;
    stb.parOdd  = fmtParOdd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      tickCnt   <= '0;
      bitCnt    <= '0;
      stopCnt   <= 1'b0;
      fmtBits   <= 4'd8;
      fmtParOn  <= 1'b0;
      fmtParOdd <= 1'b0;
      fmtTwo    <= 1'b0;
    end else if (tick) begin
      unique case (state)
        S_IDLE: begin
          tickCnt <= '0;
          if (!rxdS) begin
            state     <= S_START;
            fmtBits   <= 4'd5 + {2'b00, dataBitsSel};
            fmtParOn  <= (parityMode == 2'd1) || (parityMode == 2'd2);
            fmtParOdd <= (parityMode == 2'd2);
            fmtTwo    <= twoStop;
          end
        end
        S_START: begin
          if (tickCnt == MID_PT) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= rxdS ? S_IDLE : S_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_DATA: begin
          if (atEnd) begin
            tickCnt <= '0;
            if (bitCnt == fmtBits - 4'd1) begin
              stopCnt <= 1'b0;
              state   <= fmtParOn ? S_PAR : S_STOP;
            end else begin
              bitCnt <= bitCnt + 4'd1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_PAR: begin
          if (atEnd) begin
            tickCnt <= '0;
            stopCnt <= 1'b0;
            state   <= S_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_STOP: begin
          if (atEnd) begin
            tickCnt <= '0;
            if (stopCnt == fmtTwo) state <= S_IDLE;
            else                   stopCnt <= 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxfb_dpath.sv
module rxfb_dpath
  import rxfb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        stb,
  input  logic              rdEn,
  input  logic              errClr,
  output logic [WORD_W-1:0] rdData,
  output logic              empty,
  output logic              full,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrunErr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WORD_W-1:0] shReg;
  logic              parAcc;
  logic              parBit;
  logic              stopBad;
  logic [3:0]        shAmt;
  logic [WORD_W-1:0] word;
  logic              stopFail;
  logic              parFail;
  logic              good;
  logic              pop;
  logic              push;
  logic              ovfl;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  count;
  logic [DEPTH-1:0]  wrSel;
  logic [WORD_W-1:0] mem [DEPTH];

  // Frame assembly: shift in from the top, align at the end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      parAcc  <= 1'b0;
      parBit  <= 1'b0;
      stopBad <= 1'b0;
    end else if (stb.start) begin
      shReg   <= '0;
      parAcc  <= 1'b0;
      parBit  <= 1'b0;
      stopBad <= 1'b0;
    end else begin
      if (stb.dataStb) begin
        shReg  <= {stb.bitVal, shReg[WORD_W-1:1]};
        parAcc <= parAcc ^ stb.bitVal;
      end
      if (stb.parStb) parBit <= stb.bitVal;
      if (stb.stopStb && !stb.bitVal) stopBad <= 1'b1;
    end
  end

  assign shAmt    = 4'(WORD_W) - stb.nData;
  assign word     = shReg >> shAmt;
  assign stopFail = stopBad || !stb.bitVal;
  assign parFail  = stb.parOn && (parAcc ^ parBit ^ stb.parOdd);
  assign good     = stb.done && !stopFail && !parFail;

  // Buffer control
  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign pop   = rdEn && !empty;
  assign push  = good && (!full || pop);
  assign ovfl  = good && full && !pop;

  for (genvar i = 0; i < DEPTH; i++) begin : g_wrSel
    assign wrSel[i] = push && (wrPtr == PTR_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wrSel[i]) mem[i] <= word;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign rdData = mem[rdPtr];

  // Sticky flags: a new event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      parityErr  <= (parityErr && !errClr) || (stb.done && parFail);
      frameErr   <= (frameErr && !errClr) || (stb.done && stopFail);
      overrunErr <= (overrunErr && !errClr) || ovfl;
    end
  end
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
  import rxfb_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int DEPTH = 4,
  parameter int OSR   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxd,
  input  logic [1:0]        dataBitsSel,
  input  logic [1:0]        parityMode,
  input  logic              twoStop,
  input  logic [DIV_W-1:0]  tickDiv,
  input  logic              rdEn,
  input  logic              errClr,
  output logic [WORD_W-1:0] rdData,
  output logic              empty,
  output logic              full,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrunErr
);
  rxStrobes_t stb;

  rxfb_ctrl #(.DIV_W(DIV_W), .OSR(OSR)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxd(rxd), .dataBitsSel(dataBitsSel),
    .parityMode(parityMode), .twoStop(twoStop), .tickDiv(tickDiv), .stb(stb)
  );

  rxfb_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .rdEn(rdEn), .errClr(errClr),
    .rdData(rdData), .empty(empty), .full(full), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr)
  );
endmodule

// File: rtl/rxfb_chk.sv
module rxfb_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdEn,
  input logic       errClr,
  input logic [7:0] rdData,
  input logic       empty,
  input logic       full,
  input logic       parityErr,
  input logic       frameErr,
  input logic       overrunErr
);
  p_not_both_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(empty && full));

  p_empty_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    empty |=> !full);

  p_full_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (full && !rdEn) |=> full);

  p_head_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && !rdEn) |=> $stable(rdData));

  p_ovr_needs_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(full));

  p_sticky_par_r8: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !errClr) |=> parityErr);

  p_sticky_frm_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !errClr) |=> frameErr);

  p_sticky_ovr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overrunErr && !errClr) |=> overrunErr);
endmodule

bind rx_frame_buffer rxfb_chk u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .errClr(errClr), .rdData(rdData),
  .empty(empty), .full(full), .parityErr(parityErr), .frameErr(frameErr),
  .overrunErr(overrunErr)
);

// File: tb/rx_frame_buffer_tb.sv
`timescale 1ns/1ps
module rx_frame_buffer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxd = 1'b1;
  logic [1:0]  dataBitsSel = 2'd3;
  logic [1:0]  parityMode = 2'd0;
  logic        twoStop = 1'b0;
  logic [11:0] tickDiv = '0;
  logic        rdEn = 1'b0;
  logic        errClr = 1'b0;
  logic [7:0]  rdData;
  logic        empty, full, parityErr, frameErr, overrunErr;

  int checks = 0;
  int fails = 0;
  int divSet = 0;
  int edgeNo = 0;
  int evtAt = -1;
  bit evtPar, evtFrm, evtGood;
  logic [7:0] evtWord;
  bit trackOn = 1'b0;

  logic [7:0] q[$];
  bit mPar, mFrm, mOvr;

  always #5 clk = ~clk;

  rx_frame_buffer u_dut (
    .clk(clk), .rstN(rstN), .rxd(rxd), .dataBitsSel(dataBitsSel),
    .parityMode(parityMode), .twoStop(twoStop), .tickDiv(tickDiv),
    .rdEn(rdEn), .errClr(errClr), .rdData(rdData), .empty(empty),
    .full(full), .parityErr(parityErr), .frameErr(frameErr),
    .overrunErr(overrunErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: read applied before write, clear before set
  always @(posedge clk) begin
    bit fullB, doPop;
    edgeNo++;
    if (!rstN) begin
      q.delete();
      mPar = 0; mFrm = 0; mOvr = 0;
    end else begin
      fullB = (q.size() == 4);
      doPop = rdEn && (q.size() > 0);
      if (errClr) begin mPar = 0; mFrm = 0; mOvr = 0; end
      if (doPop) void'(q.pop_front());
      if (edgeNo == evtAt) begin
        if (evtPar) mPar = 1;
        if (evtFrm) mFrm = 1;
        if (evtGood) begin
          if (!fullB || doPop) q.push_back(evtWord);
          else mOvr = 1;
        end
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && trackOn) begin
      check("R5/R10 empty", 32'(empty), 32'(q.size() == 0));
      check("R5 full", 32'(full), 32'(q.size() == 4));
      if (q.size() > 0) check("R4 rdData", 32'(rdData), 32'(q[0]));
      check("R2/R8 parityErr", 32'(parityErr), 32'(mPar));
      check("R3/R8 frameErr", 32'(frameErr), 32'(mFrm));
      check("R6/R8 overrunErr", 32'(overrunErr), 32'(mOvr));
    end
  end

  // Drive one frame; badStop is the stop index driven low (-1 for none)
  task automatic sendFrame(input logic [7:0] w, input int nb, input int pm,
                           input int ns, input bit flipPar, input int badStop,
                           input bit track);
    logic [7:0] m;
    bit bits[$];
    bit p;
    int k;
    m = w & 8'((1 << nb) - 1);
    p = ^m;
    dataBitsSel = 2'(nb - 5);
    parityMode = 2'(pm);
    twoStop = (ns == 2);
    bits.push_back(1'b0);
    for (int i = 0; i < nb; i++) bits.push_back(m[i]);
    if (pm == 1) bits.push_back(p ^ flipPar);
    if (pm == 2) bits.push_back(~p ^ flipPar);
    for (int i = 0; i < ns; i++) bits.push_back(i != badStop);
    k = bits.size() - 1;
    evtPar = flipPar && (pm != 0);
    evtFrm = (badStop >= 0);
    evtGood = !evtPar && !evtFrm;
    evtWord = m;
    evtAt = track ? (edgeNo + 11 + 16 * k) : -1;
    foreach (bits[i]) begin
      rxd = bits[i];
      repeat (16 * (divSet + 1)) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (32 * (divSet + 1)) @(negedge clk);
  endtask

  task automatic readWord(input logic [7:0] exp, input string tag);
    check({tag, " not empty before read"}, 32'(empty), 32'd0);
    check({tag, " read value"}, 32'(rdData), 32'(exp));
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic clearFlags();
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 empty", 32'(empty), 32'd1);
    check("R11 full", 32'(full), 32'd0);
    check("R11 rdData", 32'(rdData), 32'd0);
    check("R11 flags", {29'd0, parityErr, frameErr, overrunErr}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    trackOn = 1'b1;

    // R1/R10: 8 data bits, exact completion edge
    fork
      sendFrame(8'hA5, 8, 0, 1, 0, -1, 1);
      begin
        #1;
        wait (edgeNo == evtAt - 1);
        @(negedge clk);
        check("R10 still empty before edge", 32'(empty), 32'd1);
        @(negedge clk);
        check("R10 stored at edge", 32'(empty), 32'd0);
      end
    join
    readWord(8'hA5, "R1 8-bit");

    // R1: 5 data bits, zero-extended
    sendFrame(8'hF3, 5, 0, 1, 0, -1, 1);
    readWord(8'h13, "R1 5-bit");

    // R2: even and odd parity, correct
    sendFrame(8'h55, 7, 1, 1, 0, -1, 1);
    sendFrame(8'h2A, 6, 2, 1, 0, -1, 1);
    readWord(8'h55, "R2 even");
    readWord(8'h2A, "R2 odd");

    // R2: wrong parity rejected, flag set; R8 clear
    sendFrame(8'h3C, 8, 1, 1, 1, -1, 1);
    check("R2 parity reject empty", 32'(empty), 32'd1);
    check("R2 parityErr set", 32'(parityErr), 32'd1);
    repeat (20) @(negedge clk);
    check("R8 parityErr held", 32'(parityErr), 32'd1);
    clearFlags();
    check("R8 parityErr cleared", 32'(parityErr), 32'd0);

    // R3: two stop bits, second low
    sendFrame(8'h81, 8, 2, 2, 0, 1, 1);
    check("R3 frame reject empty", 32'(empty), 32'd1);
    check("R3 frameErr set", 32'(frameErr), 32'd1);
    clearFlags();
    sendFrame(8'h7E, 8, 0, 2, 0, -1, 1);
    readWord(8'h7E, "R3 two stops");

    // R9: start glitch shorter than half a bit
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    check("R9 glitch no store", 32'(empty), 32'd1);
    check("R9 glitch no flag", {29'd0, parityErr, frameErr, overrunErr}, 32'd0);

    // R4: read on empty ignored
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check("R4 empty read ignored", 32'(empty), 32'd1);

    // R5/R6: fill, then overrun
    sendFrame(8'h11, 8, 0, 1, 0, -1, 1);
    sendFrame(8'h22, 8, 0, 1, 0, -1, 1);
    sendFrame(8'h33, 8, 0, 1, 0, -1, 1);
    check("R5 not full at three", 32'(full), 32'd0);
    sendFrame(8'h44, 8, 0, 1, 0, -1, 1);
    check("R5 full at four", 32'(full), 32'd1);
    sendFrame(8'h99, 8, 0, 1, 0, -1, 1);
    check("R6 overrunErr set", 32'(overrunErr), 32'd1);
    check("R6 still full", 32'(full), 32'd1);
    readWord(8'h11, "R6/R4 order 1");
    readWord(8'h22, "R6/R4 order 2");
    readWord(8'h33, "R6/R4 order 3");
    readWord(8'h44, "R6/R4 order 4");
    check("R5 empty after drain", 32'(empty), 32'd1);
    clearFlags();

    // R7: read coincides with completion while full
    sendFrame(8'h01, 8, 0, 1, 0, -1, 1);
    sendFrame(8'h02, 8, 0, 1, 0, -1, 1);
    sendFrame(8'h03, 8, 0, 1, 0, -1, 1);
    sendFrame(8'h04, 8, 0, 1, 0, -1, 1);
    fork
      sendFrame(8'h05, 8, 0, 1, 0, -1, 1);
      begin
        #1;
        wait (edgeNo == evtAt - 1);
        @(negedge clk);
        check("R7 head before", 32'(rdData), 32'h01);
        rdEn = 1'b1;
        @(negedge clk);
        rdEn = 1'b0;
      end
    join
    check("R7 no overrun", 32'(overrunErr), 32'd0);
    check("R7 still full", 32'(full), 32'd1);
    readWord(8'h02, "R7 drain 1");
    readWord(8'h03, "R7 drain 2");
    readWord(8'h04, "R7 drain 3");
    readWord(8'h05, "R7 drain 4");

    // R8: clear in the same cycle as a new framing error
    fork
      sendFrame(8'h6B, 8, 0, 1, 0, 0, 1);
      begin
        #1;
        wait (edgeNo == evtAt - 1);
        @(negedge clk);
        errClr = 1'b1;
        @(negedge clk);
        errClr = 1'b0;
        check("R8 set wins over clear", 32'(frameErr), 32'd1);
      end
    join
    clearFlags();

    // R9: divided tick rate, 6 bits odd parity
    trackOn = 1'b0;
    divSet = 3;
    tickDiv = 12'd3;
    repeat (8) @(negedge clk);
    sendFrame(8'h2D, 6, 2, 1, 0, -1, 0);
    q.push_back(8'h2D);
    trackOn = 1'b1;
    @(negedge clk);
    readWord(8'h2D, "R9 divided rate");
    check("R9 no flags", {29'd0, parityErr, frameErr, overrunErr}, 32'd0);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule